// File: doc/BRIEF.md
# Strided Vector Transfer Engine

This engine moves whole vectors between a wide on-chip vector memory, where each row holds `LANES` words and is read or written in a single access, and a narrow external memory that takes one word per transfer. A load command gathers words from external memory and writes them as consecutive vector rows. A store command reads consecutive vector rows and scatters their words to external memory. Each vector row costs exactly one access to the shared vector memory. The external side needs `LANES` word transfers per row, so the engine leaves the shared memory free for its other users most of the time.

External addressing works in bursts. Words inside a burst sit at consecutive addresses. Each new burst starts `stride` words after the start of the previous burst. Bursts run on across vector boundaries, so one burst may end in one vector and continue in the next. The engine requests the shared memory through a request/grant pair. It raises a priority flag when one of its requests has waited too long, and an arbiter outside the block can use that flag to change priority while the system runs.

Top module: `vec_xfer_engine`

## Requirements
- R1: After reset, and whenever no command is running, `busy`, `done`, `vm_req`, `vm_prio` and `ext_valid` are all 0.
- R2: A load with count N fills vector rows `vaddr` to `vaddr+N-1`. Lane i of a row occupies bits `[i*WORD_W +: WORD_W]` and holds the i-th external word taken for that row.
- R3: A store with count N reads rows `vaddr` to `vaddr+N-1` and sends lane 0 first and lane `LANES-1` last. Each word goes to the external address that the R4 sequence assigns to it.
- R4: The n-th external word of a command (n counted from 0 across the whole command) goes to address `saddr + (n / B) * stride + (n % B)`, reduced modulo 2^SADDR_W. B is the burst length, and a burst length of 0 is treated as 1. The command makes exactly `N*LANES` external transfers.
- R5: A command with count N makes exactly N granted vector-memory accesses. `vm_we` is 1 only while `vm_req` is 1.
- R6: `done` is a one-cycle pulse. It is high in the cycle after the final granted row write of a load, or after the final accepted external word of a store. `busy` is 0 while `done` is high.
- R7: A command offered while `busy` is 1 is dropped. It causes no memory access or external transfer, neither at the time nor later.
- R8: A command with count 0 makes no accesses. `done` is high in the cycle after the command is accepted, and `busy` stays 0.
- R9: Once `vm_req` is raised, it stays high with `vm_addr` and `vm_we` unchanged until a cycle in which `vm_grant` is 1.
- R10: `vm_prio` is 1 exactly when the current request has been denied for `AGE_LIMIT` or more consecutive cycles. It is 0 once the request is granted.
- R11: Once `ext_valid` is raised, it stays high with `ext_addr` and `ext_write` unchanged until a cycle in which `ext_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered; taken only while idle |
| cmd_store | input | 1 | 1 = store (vector to external), 0 = load |
| cmd_count | input | CNT_W | Number of vector rows |
| cmd_vaddr | input | VADDR_W | First vector row |
| cmd_saddr | input | SADDR_W | First external word address |
| cmd_burst | input | SADDR_W | Words per burst (0 counts as 1) |
| cmd_stride | input | SADDR_W | Distance between burst starts |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion pulse |
| vm_req | output | 1 | Vector-memory access request |
| vm_we | output | 1 | Request is a row write |
| vm_addr | output | VADDR_W | Row address of the request |
| vm_wdata | output | LANES*WORD_W | Row data for a write |
| vm_grant | input | 1 | Request granted this cycle |
| vm_rdata | input | LANES*WORD_W | Row read data, valid the cycle after a granted read |
| vm_prio | output | 1 | Request has aged; ask for higher priority |
| ext_valid | output | 1 | External word transfer offered |
| ext_write | output | 1 | 1 = write word out, 0 = read word in |
| ext_addr | output | SADDR_W | External word address |
| ext_wdata | output | WORD_W | Word being written |
| ext_ready | input | 1 | External side accepts the transfer this cycle |
| ext_rdata | input | WORD_W | Read word, valid with ext_ready |

## Verification
Each external address is captured on the clock edge where `ext_valid` and `ext_ready` are both high. It is then compared with the burst-and-stride formula, computed afresh for every word index. The cycle of the last granted access or transfer is logged. `done` must appear at exactly that cycle plus one, and for a zero-count command it must already be high at the first falling edge after the command is accepted. The priority flag is sampled at every falling edge of a forced denial, so it is due on the `AGE_LIMIT`-th denied cycle and must drop in the cycle after the grant. The memory contents are compared only after `done`, with all stimulus driven on falling edges.

// File: rtl/vxe_pkg.sv
package vxe_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_CAP,
    S_SEND,
    S_RECV,
    S_WR_REQ
  } xfer_state_t;
endpackage

// File: rtl/vxe_addr_gen.sv
// External word address walker: base of current burst plus offset in burst.
module vxe_addr_gen #(
  parameter int SADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SADDR_W-1:0] start_addr,
  input  logic [SADDR_W-1:0] burst_len,
  input  logic [SADDR_W-1:0] stride,
  input  logic               step,
  output logic [SADDR_W-1:0] addr
);
  logic [SADDR_W-1:0] base_q, off_q, burst_q, stride_q;
  logic               burst_end;

  // A zero burst length ends every burst after a single word.
  assign burst_end = ({1'b0, off_q} + 1'b1) >= {1'b0, burst_q};
  assign addr      = base_q + off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      off_q    <= '0;
      burst_q  <= '0;
      stride_q <= '0;
    end else if (start) begin
      base_q   <= start_addr;
      off_q    <= '0;
      burst_q  <= burst_len;
      stride_q <= stride;
    end else if (step) begin
      if (burst_end) begin
        base_q <= base_q + stride_q;
        off_q  <= '0;
      end else begin
        off_q  <= off_q + 1'b1;
      end
    end
  end

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!step && !start) |=> $stable(addr));
endmodule

// File: rtl/vxe_lane_buf.sv
// One row of lanes: filled whole from vector memory or one word at a time.
module vxe_lane_buf #(
  parameter int LANES  = 4,
  parameter int WORD_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_vec,
  input  logic [LANES*WORD_W-1:0] vec_in,
  input  logic                    put_word,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]       word_in,
  output logic [LANES*WORD_W-1:0] vec_out,
  output logic [WORD_W-1:0]       word_out
);
  logic [WORD_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        lane_q[g] <= '0;
      else if (load_vec)
        lane_q[g] <= vec_in[g*WORD_W +: WORD_W];
      else if (put_word && idx == IDX_W'(g))
        lane_q[g] <= word_in;
    end
    assign vec_out[g*WORD_W +: WORD_W] = lane_q[g];
  end

  assign word_out = lane_q[idx];
endmodule

// File: rtl/vxe_ctrl.sv
// Sequencer: one shared-memory access per row, LANES external words per row.
module vxe_ctrl
  import vxe_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int IDX_W     = 2,
  parameter int VADDR_W   = 4,
  parameter int CNT_W     = 4,
  parameter int AGE_LIMIT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic               cmd_store,
  input  logic [CNT_W-1:0]   cmd_count,
  input  logic [VADDR_W-1:0] cmd_vaddr,
  input  logic               vm_grant,
  input  logic               ext_ready,
  output logic               busy,
  output logic               done,
  output logic               vm_req,
  output logic               vm_we,
  output logic [VADDR_W-1:0] vm_addr,
  output logic               vm_prio,
  output logic               ext_valid,
  output logic               ext_write,
  output logic               start,
  output logic               step,
  output logic               load_vec,
  output logic               put_word,
  output logic [IDX_W-1:0]   idx
);
  localparam int AGE_W = $clog2(AGE_LIMIT + 1);

  xfer_state_t        state_q;
  logic [VADDR_W-1:0] vptr_q;
  logic [CNT_W-1:0]   left_q;
  logic [IDX_W-1:0]   idx_q;
  logic [AGE_W-1:0]   wait_q;
  logic               done_q;
  logic               last_lane, last_vec;

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign vm_req    = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign vm_we     = (state_q == S_WR_REQ);
  assign vm_addr   = vptr_q;
  assign vm_prio   = vm_req && (wait_q >= AGE_W'(AGE_LIMIT));
  assign ext_valid = (state_q == S_SEND) || (state_q == S_RECV);
  assign ext_write = (state_q == S_SEND);
  assign start     = (state_q == S_IDLE) && cmd_valid;
  assign step      = ext_valid && ext_ready;
  assign load_vec  = (state_q == S_RD_CAP);
  assign put_word  = (state_q == S_RECV) && ext_ready;
  assign idx       = idx_q;
  assign last_lane = (idx_q == IDX_W'(LANES - 1));
  assign last_vec  = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      vptr_q  <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid) begin
          vptr_q <= cmd_vaddr;
          left_q <= cmd_count;
          idx_q  <= '0;
          if (cmd_count == '0) done_q  <= 1'b1;
          else                 state_q <= cmd_store ? S_RD_REQ : S_RECV;
        end
        S_RD_REQ: if (vm_grant) state_q <= S_RD_CAP;
        S_RD_CAP: begin
          idx_q   <= '0;
          state_q <= S_SEND;
        end
        S_SEND: if (ext_ready) begin
          if (!last_lane) begin
            idx_q <= idx_q + 1'b1;
          end else begin
            idx_q <= '0;
            if (last_vec) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end else begin
              left_q  <= left_q - 1'b1;
              vptr_q  <= vptr_q + 1'b1;
              state_q <= S_RD_REQ;
            end
          end
        end
        S_RECV: if (ext_ready) begin
          if (!last_lane) begin
            idx_q <= idx_q + 1'b1;
          end else begin
            idx_q   <= '0;
            state_q <= S_WR_REQ;
          end
        end
        S_WR_REQ: if (vm_grant) begin
          if (last_vec) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            left_q  <= left_q - 1'b1;
            vptr_q  <= vptr_q + 1'b1;
            state_q <= S_RECV;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Age of the pending request, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst || !vm_req || vm_grant) wait_q <= '0;
    else if (wait_q < AGE_W'(AGE_LIMIT)) wait_q <= wait_q + 1'b1;
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (vm_req && !vm_grant) |=> (vm_req && $stable(vm_addr) && $stable(vm_we)));
  p_ext_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_write) && $stable(idx_q)));
  p_we_in_req_r5: assert property (@(posedge clk) disable iff (rst)
    vm_we |-> vm_req);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_prio_aged_r10: assert property (@(posedge clk) disable iff (rst)
    vm_prio |-> (vm_req && $past(vm_req) && !$past(vm_grant)));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!vm_req && !ext_valid && !vm_prio));
endmodule

// File: rtl/vec_xfer_engine.sv
module vec_xfer_engine #(
  parameter int LANES     = 4,   // words per vector row, power of two >= 2
  parameter int WORD_W    = 16,
  parameter int VADDR_W   = 4,
  parameter int SADDR_W   = 8,
  parameter int CNT_W     = 4,
  parameter int AGE_LIMIT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  input  logic                    cmd_store,
  input  logic [CNT_W-1:0]        cmd_count,
  input  logic [VADDR_W-1:0]      cmd_vaddr,
  input  logic [SADDR_W-1:0]      cmd_saddr,
  input  logic [SADDR_W-1:0]      cmd_burst,
  input  logic [SADDR_W-1:0]      cmd_stride,
  output logic                    busy,
  output logic                    done,
  output logic                    vm_req,
  output logic                    vm_we,
  output logic [VADDR_W-1:0]      vm_addr,
  output logic [LANES*WORD_W-1:0] vm_wdata,
  input  logic                    vm_grant,
  input  logic [LANES*WORD_W-1:0] vm_rdata,
  output logic                    vm_prio,
  output logic                    ext_valid,
  output logic                    ext_write,
  output logic [SADDR_W-1:0]      ext_addr,
  output logic [WORD_W-1:0]       ext_wdata,
  input  logic                    ext_ready,
  input  logic [WORD_W-1:0]       ext_rdata
);
  localparam int IDX_W = $clog2(LANES);

  logic             start, step, load_vec, put_word;
  logic [IDX_W-1:0] idx;

  vxe_ctrl #(
    .LANES(LANES), .IDX_W(IDX_W), .VADDR_W(VADDR_W),
    .CNT_W(CNT_W), .AGE_LIMIT(AGE_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_store(cmd_store),
    .cmd_count(cmd_count), .cmd_vaddr(cmd_vaddr),
    .vm_grant(vm_grant), .ext_ready(ext_ready),
    .busy(busy), .done(done),
    .vm_req(vm_req), .vm_we(vm_we), .vm_addr(vm_addr), .vm_prio(vm_prio),
    .ext_valid(ext_valid), .ext_write(ext_write),
    .start(start), .step(step), .load_vec(load_vec),
    .put_word(put_word), .idx(idx)
  );

  vxe_addr_gen #(.SADDR_W(SADDR_W)) u_addr (
    .clk(clk), .rst(rst), .start(start),
    .start_addr(cmd_saddr), .burst_len(cmd_burst), .stride(cmd_stride),
    .step(step), .addr(ext_addr)
  );

  vxe_lane_buf #(.LANES(LANES), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst(rst),
    .load_vec(load_vec), .vec_in(vm_rdata),
    .put_word(put_word), .idx(idx), .word_in(ext_rdata),
    .vec_out(vm_wdata), .word_out(ext_wdata)
  );
endmodule

// File: tb/vec_xfer_engine_bench.sv
module vec_xfer_engine_bench;
  localparam int LANES = 4, WORD_W = 16, VADDR_W = 4, SADDR_W = 8, CNT_W = 4, AGE = 4;
  localparam int VW = LANES * WORD_W;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_store = 1'b0;
  logic [CNT_W-1:0]   cmd_count = '0;
  logic [VADDR_W-1:0] cmd_vaddr = '0;
  logic [SADDR_W-1:0] cmd_saddr = '0, cmd_burst = '0, cmd_stride = '0;
  logic busy, done, vm_req, vm_we, vm_prio, vm_grant;
  logic [VADDR_W-1:0] vm_addr;
  logic [VW-1:0] vm_wdata, vm_rdata;
  logic ext_valid, ext_write, ext_ready;
  logic [SADDR_W-1:0] ext_addr;
  logic [WORD_W-1:0] ext_wdata, ext_rdata;

  logic vm_deny = 1'b0, stall_mode = 1'b0;
  logic [VW-1:0] vmem [16];
  logic [WORD_W-1:0] emem [256];
  logic [SADDR_W-1:0] log_addr [256];
  int log_n = 0, grant_n = 0, done_n = 0, cyc = 0, last_evt = 0, done_cyc = 0, ncyc = 0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  vec_xfer_engine #(.LANES(LANES), .WORD_W(WORD_W), .VADDR_W(VADDR_W),
    .SADDR_W(SADDR_W), .CNT_W(CNT_W), .AGE_LIMIT(AGE)) u_vec_xfer_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
    .cmd_count(cmd_count), .cmd_vaddr(cmd_vaddr), .cmd_saddr(cmd_saddr),
    .cmd_burst(cmd_burst), .cmd_stride(cmd_stride), .busy(busy), .done(done),
    .vm_req(vm_req), .vm_we(vm_we), .vm_addr(vm_addr), .vm_wdata(vm_wdata),
    .vm_grant(vm_grant), .vm_rdata(vm_rdata), .vm_prio(vm_prio),
    .ext_valid(ext_valid), .ext_write(ext_write), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ready(ext_ready), .ext_rdata(ext_rdata));

  assign vm_grant  = vm_req && !vm_deny;
  assign ext_rdata = emem[ext_addr];

  // Memory models and event monitor.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) vmem[i] <= {VW{1'b0}} | (64'h1111_2222_3333_4444 * (i + 1));
      for (int i = 0; i < 256; i++) emem[i] <= WORD_W'(i * 37 + 5);
    end else begin
      if (vm_req && vm_grant) begin
        if (vm_we) vmem[vm_addr] <= vm_wdata;
        else       vm_rdata <= vmem[vm_addr];
        grant_n  <= grant_n + 1;
        last_evt <= cyc;
      end
      if (ext_valid && ext_ready) begin
        if (ext_write) emem[ext_addr] <= ext_wdata;
        log_addr[log_n[7:0]] <= ext_addr;
        log_n    <= log_n + 1;
        last_evt <= cyc;
      end
      if (done) begin
        done_n   <= done_n + 1;
        done_cyc <= cyc;
      end
    end
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    ext_ready <= !(stall_mode && (ncyc % 3 == 1));
    ncyc <= ncyc + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [SADDR_W-1:0] exp_addr(int sa, int bl, int st, int n);
    int b = (bl == 0) ? 1 : bl;
    return SADDR_W'(sa + (n / b) * st + (n % b));
  endfunction

  task automatic issue(input bit st, input int cnt, input int va, input int sa,
                       input int bl, input int stride);
    @(negedge clk);
    cmd_store = st; cmd_count = CNT_W'(cnt); cmd_vaddr = VADDR_W'(va);
    cmd_saddr = SADDR_W'(sa); cmd_burst = SADDR_W'(bl); cmd_stride = SADDR_W'(stride);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(t < 2000, "R6 done seen", t, 0);
    @(negedge clk);
  endtask

  // Full checks of one command already issued; bases taken before issue.
  task automatic verify(input bit st, input int cnt, input int va, input int sa,
                        input int bl, input int stride, input int b_log, input int b_g,
                        input int b_d);
    check(log_n - b_log == cnt * LANES, "R4 transfer count", log_n - b_log, cnt * LANES);
    for (int n = 0; n < cnt * LANES; n++)
      check(log_addr[b_log + n] == exp_addr(sa, bl, stride, n), "R4 address",
            log_addr[b_log + n], exp_addr(sa, bl, stride, n));
    check(grant_n - b_g == cnt, "R5 access count", grant_n - b_g, cnt);
    check(done_n - b_d == 1, "R6 single done", done_n - b_d, 1);
    check(done_cyc == last_evt + 1, "R6 done timing", done_cyc, last_evt + 1);
    for (int n = 0; n < cnt * LANES; n++) begin
      logic [WORD_W-1:0] lane_v, ext_v;
      lane_v = vmem[va + n / LANES][(n % LANES) * WORD_W +: WORD_W];
      ext_v  = emem[exp_addr(sa, bl, stride, n)];
      if (st) check(ext_v == lane_v, "R3 stored word", ext_v, lane_v);
      else    check(lane_v == ext_v, "R2 loaded lane", lane_v, ext_v);
    end
  endtask

  task automatic run_xfer(input bit st, input int cnt, input int va, input int sa,
                          input int bl, input int stride);
    int b_log = log_n, b_g = grant_n, b_d = done_n;
    issue(st, cnt, va, sa, bl, stride);
    wait_done();
    verify(st, cnt, va, sa, bl, stride, b_log, b_g, b_d);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({busy, done, vm_req, vm_prio, ext_valid} == 5'b0, "R1 idle outputs",
          {busy, done, vm_req, vm_prio, ext_valid}, 0);
  endtask

  task automatic t_count_zero();
    int b_log = log_n, b_g = grant_n;
    issue(1'b0, 0, 3, 10, 4, 4);
    check(done == 1'b1, "R8 done after accept", done, 1);
    check(busy == 1'b0, "R8 stays idle", busy, 0);
    repeat (3) @(negedge clk);
    check(log_n == b_log && grant_n == b_g, "R8 no accesses", log_n - b_log + grant_n - b_g, 0);
    check(done == 1'b0, "R1 idle after zero count", done, 0);
  endtask

  task automatic t_busy_ignore();
    int b_log = log_n, b_g = grant_n, b_d = done_n;
    logic [VW-1:0] sentinel = vmem[12];
    issue(1'b0, 2, 10, 20, 4, 4);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R7 busy mid command", busy, 1);
    issue(1'b0, 1, 12, 200, 4, 4);
    wait_done();
    repeat (20) @(negedge clk);
    verify(1'b0, 2, 10, 20, 4, 4, b_log, b_g, b_d);
    check(busy == 1'b0, "R7 dropped command never runs", busy, 0);
    check(vmem[12] == sentinel, "R7 target row untouched", vmem[12], sentinel);
    check(log_n - b_log == 2 * LANES, "R7 no extra transfers", log_n - b_log, 2 * LANES);
  endtask

  task automatic t_priority();
    int b_log = log_n, b_g = grant_n, b_d = done_n;
    vm_deny = 1'b1;
    issue(1'b1, 1, 5, 150, 4, 4);
    check(vm_req == 1'b1, "R9 request raised", vm_req, 1);
    for (int w = 0; w < 6; w++) begin
      check(vm_prio == (w >= AGE), "R10 aging flag", vm_prio, w >= AGE);
      check(vm_req == 1'b1, "R9 request held", vm_req, 1);
      if (w < 5) @(negedge clk);
    end
    vm_deny = 1'b0;
    @(negedge clk);
    check(vm_prio == 1'b0, "R10 flag cleared after grant", vm_prio, 0);
    wait_done();
    verify(1'b1, 1, 5, 150, 4, 4, b_log, b_g, b_d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();                                     // R1
    run_xfer(1'b0, 2, 0, 16, 4, 4);                // R2 contiguous load
    stall_mode = 1'b1;
    run_xfer(1'b1, 2, 0, 100, 2, 10);              // R3 strided store with stalls
    run_xfer(1'b0, 3, 5, 40, 3, 7);                // R4 bursts cross row boundary
    run_xfer(1'b0, 1, 8, 60, 0, 5);                // R4 zero burst length
    stall_mode = 1'b0;
    t_count_zero();                                // R8
    t_busy_ignore();                               // R7
    t_priority();                                  // R10
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule